// File: doc/BRIEF.md
# Compare and condition flag unit

This block produces the five condition flags of a register-to-operand comparison. It subtracts an operand from a register value, throws the difference away, and keeps only the flags: carry/borrow, two's complement overflow, zero, negative and half carry. The register being compared is never written. Only the flag register changes.

A comparison is either narrow (8 bits) or wide (16 bits). In a narrow compare the low byte of the register input is compared with the byte fetched from address M. In a wide compare the full 16-bit register input is compared with a big-endian operand: the byte from M forms the upper half and the byte from M+1 forms the lower half. A one-cycle strobe captures the inputs. At that clock edge the flags update, and a write-enable mask shows for one cycle which flags took new values. A wide compare leaves the half-carry flag as it was.

Top module: `cmp_flag_unit`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `flags_q` and `upd_mask` are all zero.
- R2: After a strobed compare, C (`flags_q[0]`) is 1 exactly when the register value, taken as unsigned, is less than the operand, which means the subtraction borrows out of its top bit.
- R3: After a strobed compare, V (`flags_q[1]`) is 1 exactly when the signed difference of the register value and the operand lies outside the signed range of the selected width.
- R4: After a strobed compare, Z (`flags_q[2]`) is 1 exactly when the difference over the selected width is zero.
- R5: After a strobed compare, N (`flags_q[3]`) equals the top bit of the difference over the selected width.
- R6: After a narrow compare (`wide`=0), H (`flags_q[4]`) is 1 exactly when bits 3:0 of the register value are less than bits 3:0 of the operand, which means the subtraction borrows from bit 4 into bit 3.
- R7: A wide compare (`wide`=1) leaves H at the value it had before.
- R8: A wide operand is {`opnd_m`, `opnd_m1`}, with `opnd_m` as bits 15:8. A narrow compare uses `reg_val[7:0]` and `opnd_m` only, so `reg_val[15:8]` and `opnd_m1` have no effect on it.
- R9: In a cycle without `strobe`, no flag changes, whatever the other inputs do.
- R10: In the cycle after a strobe, `upd_mask` is 5'b11111 for a narrow compare and 5'b01111 for a wide compare. In every other cycle it is 5'b00000. Both `upd_mask` and `flags_q` use this bit layout: [4]=H, [3]=N, [2]=Z, [1]=V, [0]=C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Captures a compare at this clock edge |
| wide | input | 1 | 0 = 8-bit compare, 1 = 16-bit compare |
| reg_val | input | 16 | Register value (only the low byte is used in a narrow compare) |
| opnd_m | input | 8 | Operand byte from address M |
| opnd_m1 | input | 8 | Operand byte from address M+1 (used only in a wide compare) |
| flags_q | output | 5 | Flag register {H,N,Z,V,C} |
| upd_mask | output | 5 | One-cycle mask of the flags written by the last strobe |

## Verification
The hardest case to reach is the interaction between the two widths on H. A wide compare must keep an H value that an earlier narrow compare left behind. That is only visible if the stimulus alternates widths and sets H both ways before a wide compare.

The vector table is ordered so that narrow compares leave H at 1 and at 0 before wide compares. It also includes wide operands where swapping the two bytes would change C and Z, which exposes a wrong byte order. Separate cases idle the strobe while the inputs change, and assert reset in the middle of a run.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
    localparam int NARROW_W = 8;
    localparam int WIDE_W   = 2 * NARROW_W;
    localparam int NIB_W    = 4;
    localparam int NFLAG    = 5;

    localparam int F_C = 0;
    localparam int F_V = 1;
    localparam int F_Z = 2;
    localparam int F_N = 3;
    localparam int F_H = 4;

    typedef enum logic {
        W_NARROW = 1'b0,
        W_WIDE   = 1'b1
    } cmp_width_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    typedef struct packed {
        logic [WIDE_W-1:0] diff;
        logic              borrow;
        logic              half;
        logic              sgn_r;
        logic              sgn_m;
        logic              sgn_d;
    } lane_res_t;

    function automatic logic [NFLAG-1:0] write_mask(input cmp_width_e w);
        logic [NFLAG-1:0] m;
        m = '1;
        if (w == W_WIDE) m[F_H] = 1'b0;
        return m;
    endfunction
endpackage

// File: rtl/cmpf_sub.sv
module cmpf_sub
    import cmpf_pkg::*;
#(
    parameter int NW = NARROW_W,
    parameter int WW = WIDE_W,
    parameter int NB = NIB_W
) (
    input  cmp_width_e     width_sel,
    input  logic [WW-1:0]  reg_val,
    input  logic [WW-1:0]  opnd,
    output lane_res_t      res
);
    localparam int NLANE = 2;

    lane_res_t lanes [NLANE];

    logic [NB:0] nib_d;
    assign nib_d = {1'b0, reg_val[NB-1:0]} - {1'b0, opnd[NB-1:0]};

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? NW : WW;
        logic [LW:0]   d;
        logic [WW-1:0] dz;
        assign d  = {1'b0, reg_val[LW-1:0]} - {1'b0, opnd[LW-1:0]};
        assign dz = WW'(d[LW-1:0]);
        assign lanes[g] = {dz, d[LW], nib_d[NB], reg_val[LW-1], opnd[LW-1], d[LW-1]};
    end

    assign res = (width_sel == W_WIDE) ? lanes[1] : lanes[0];
endmodule

// File: rtl/cmpf_flags.sv
module cmpf_flags
    import cmpf_pkg::*;
(
    input  lane_res_t res,
    output cc_t       cc
);
    always_comb begin
        cc.c = res.borrow;
        cc.n = res.sgn_d;
        cc.z = (res.diff == '0);
        cc.v = (res.sgn_r ^ res.sgn_m) & (res.sgn_r ^ res.sgn_d);
        cc.h = res.half;
    end
endmodule

// File: rtl/cmpf_ccreg.sv
module cmpf_ccreg
    import cmpf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  cmp_width_e       width_sel,
    input  cc_t              nxt,
    output cc_t              q,
    output logic [NFLAG-1:0] mask
);
    logic [NFLAG-1:0] wmask;
    logic [NFLAG-1:0] q_vec;
    logic [NFLAG-1:0] nxt_vec;

    assign wmask   = write_mask(width_sel);
    assign nxt_vec = nxt;
    assign q       = q_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vec <= '0;
            mask  <= '0;
        end else begin
            mask <= strobe ? wmask : '0;
            for (int i = 0; i < NFLAG; i++) begin
                if (strobe && wmask[i]) q_vec[i] <= nxt_vec[i];
            end
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(q_vec));

    p_mask_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> (mask == '0));
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
    import cmpf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe,
    input  logic        wide,
    input  logic [15:0] reg_val,
    input  logic [7:0]  opnd_m,
    input  logic [7:0]  opnd_m1,
    output logic [4:0]  flags_q,
    output logic [4:0]  upd_mask
);
    cmp_width_e        wsel;
    logic [WIDE_W-1:0] opnd;
    lane_res_t         res;
    cc_t               cc_nxt;
    cc_t               cc_q;

    assign wsel = cmp_width_e'(wide);
    assign opnd = (wsel == W_WIDE) ? {opnd_m, opnd_m1} : {{NARROW_W{1'b0}}, opnd_m};

    cmpf_sub #(.NW(NARROW_W), .WW(WIDE_W), .NB(NIB_W)) u_sub (
        .width_sel (wsel),
        .reg_val   (reg_val),
        .opnd      (opnd),
        .res       (res)
    );

    cmpf_flags u_flags (
        .res (res),
        .cc  (cc_nxt)
    );

    cmpf_ccreg u_ccreg (
        .clk       (clk),
        .rst       (rst),
        .strobe    (strobe),
        .width_sel (wsel),
        .nxt       (cc_nxt),
        .q         (cc_q),
        .mask      (upd_mask)
    );

    assign flags_q = cc_q;

    p_h_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (strobe && wide) |=> (flags_q[F_H] == $past(flags_q[F_H])));

    p_carry_narrow_r2: assert property (@(posedge clk) disable iff (rst)
        (strobe && !wide) |=> (flags_q[F_C] == ($past(reg_val[7:0]) < $past(opnd_m))));

    p_carry_wide_r2: assert property (@(posedge clk) disable iff (rst)
        (strobe && wide) |=> (flags_q[F_C] == ($past(reg_val) < $past({opnd_m, opnd_m1}))));

    p_zero_narrow_r4: assert property (@(posedge clk) disable iff (rst)
        (strobe && !wide) |=> (flags_q[F_Z] == ($past(reg_val[7:0]) == $past(opnd_m))));

    p_mask_wide_r10: assert property (@(posedge clk) disable iff (rst)
        (strobe && wide) |=> (upd_mask == 5'b01111));

    p_mask_narrow_r10: assert property (@(posedge clk) disable iff (rst)
        (strobe && !wide) |=> (upd_mask == 5'b11111));
endmodule

// File: tb/tb_cmp_flag_unit.sv
module tb_cmp_flag_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic        wide = 1'b0;
    logic [15:0] reg_val = '0;
    logic [7:0]  opnd_m = '0;
    logic [7:0]  opnd_m1 = '0;
    logic [4:0]  flags_q;
    logic [4:0]  upd_mask;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic model_h = 1'b0;

    always #5 clk = ~clk;

    cmp_flag_unit dut (
        .clk(clk), .rst(rst), .strobe(strobe), .wide(wide),
        .reg_val(reg_val), .opnd_m(opnd_m), .opnd_m1(opnd_m1),
        .flags_q(flags_q), .upd_mask(upd_mask)
    );

    // {wide, reg_val, opnd_m, opnd_m1}
    localparam int NV = 14;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 16'h0005, 8'h03, 8'h00},
        {1'b0, 16'h0003, 8'h05, 8'h00},
        {1'b0, 16'h0080, 8'h01, 8'h00},
        {1'b0, 16'h007F, 8'hFF, 8'h00},
        {1'b0, 16'h0042, 8'h42, 8'h00},
        {1'b0, 16'hAB00, 8'h00, 8'h55},  // R8: upper reg byte and M+1 ignored
        {1'b0, 16'h0010, 8'h01, 8'h00},  // leaves H=1
        {1'b1, 16'h1234, 8'h12, 8'h34},  // R7: H stays 1
        {1'b1, 16'h0001, 8'h01, 8'h00},  // R8: byte order matters
        {1'b1, 16'h8000, 8'h00, 8'h01},
        {1'b0, 16'h0011, 8'h01, 8'h00},  // leaves H=0
        {1'b1, 16'h7FFF, 8'hFF, 8'hFF},  // R7: H stays 0
        {1'b1, 16'h0100, 8'h00, 8'hFF},
        {1'b0, 16'h00FF, 8'h80, 8'h00}
    };

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_flags(input logic w, input logic [15:0] r,
                                             input logic [7:0] m, input logic [7:0] m1,
                                             input logic prev_h);
        int bits, rv, ov, lim, dv, sr, so, sd;
        logic c, v, z, n, h;
        bits = w ? 16 : 8;
        lim  = 1 << bits;
        rv   = w ? int'(r) : int'(r[7:0]);
        ov   = w ? int'({m, m1}) : int'(m);
        dv   = (rv - ov + lim) % lim;
        sr   = (rv >= lim / 2) ? rv - lim : rv;
        so   = (ov >= lim / 2) ? ov - lim : ov;
        sd   = sr - so;
        c = (rv < ov);
        z = (dv == 0);
        n = (dv >= lim / 2);
        v = (sd >= lim / 2) || (sd < -(lim / 2));
        h = w ? prev_h : ((rv % 16) < (ov % 16));
        return {h, n, z, v, c};
    endfunction

    task automatic run_cmp(input logic w, input logic [15:0] r, input logic [7:0] m,
                           input logic [7:0] m1);
        logic [4:0] exp;
        exp = ref_flags(w, r, m, m1, model_h);
        @(negedge clk);
        wide = w; reg_val = r; opnd_m = m; opnd_m1 = m1; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        chk("R2", {4'b0, flags_q[0]}, {4'b0, exp[0]});
        chk("R3", {4'b0, flags_q[1]}, {4'b0, exp[1]});
        chk("R4", {4'b0, flags_q[2]}, {4'b0, exp[2]});
        chk("R5", {4'b0, flags_q[3]}, {4'b0, exp[3]});
        chk(w ? "R7" : "R6", {4'b0, flags_q[4]}, {4'b0, exp[4]});
        chk("R10", upd_mask, w ? 5'b01111 : 5'b11111);
        model_h = exp[4];
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] held;
        repeat (3) @(negedge clk);
        chk("R1", flags_q, 5'b0);
        chk("R1", upd_mask, 5'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", flags_q, 5'b0);
        chk("R1", upd_mask, 5'b0);

        for (int i = 0; i < NV; i++) begin
            run_cmp(VEC[i][32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0]);
        end

        // mask returns to zero one cycle after the update (R10)
        @(negedge clk);
        chk("R10", upd_mask, 5'b0);

        // R9: inputs toggle with no strobe, flags hold
        held = flags_q;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            wide = k[0]; reg_val = 16'h0000; opnd_m = 8'hFF; opnd_m1 = 8'(k * 37);
            @(negedge clk);
            chk("R9", flags_q, held);
            chk("R10", upd_mask, 5'b0);
        end

        // R8: narrow compare with equal low bytes, differing upper byte and M+1
        run_cmp(1'b0, 16'hFF33, 8'h33, 8'hC7);
        chk("R8", {4'b0, flags_q[2]}, 5'b00001);

        // R7: make H=1, then a wide compare that would clear it if driven
        run_cmp(1'b0, 16'h0000, 8'h01, 8'h00);
        run_cmp(1'b1, 16'hFFFF, 8'h00, 8'h00);
        chk("R7", {4'b0, flags_q[4]}, 5'b00001);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", flags_q, 5'b0);
        chk("R1", upd_mask, 5'b0);
        rst = 1'b0;
        model_h = 1'b0;
        run_cmp(1'b1, 16'h8000, 8'h7F, 8'hFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule